// File: doc/BRIEF.md
# UART Receive DMA Request and Timeout Generator

This block watches the fill level of a UART receive FIFO and turns it into DMA requests. It forms two requests. The single-transfer request says the FIFO holds at least one character. The burst request says the FIFO has reached its watermark of three quarters full. A control input chooses which of the two drives the one request line to the DMA controller. A global enable forces every request output low. Each request drops for one cycle when the DMA controller returns the clear handshake for it. After that cycle the request is formed again from the level.

The burst the DMA controller takes is half the FIFO depth. The burst watermark sits above that size, so some characters always stay in the FIFO after a burst. Those leftover characters start the receive-timeout logic. The timer counts bit-period ticks while the FIFO holds data. A received character, a FIFO read, or an empty FIFO restarts it. When the count reaches the timeout length, an interrupt rises. The interrupt holds until software writes its clear bit or the FIFO empties.

Top module: `uart_rx_dma_req`

## Requirements
- R1: `sreq` is 1 in the cycle after the clock edge at which `rx_level` is nonzero, `dma_en` is 1 and `single_clr` is 0. Otherwise it is 0 after that edge.
- R2: `breq` is 1 in the cycle after an edge at which `rx_level` is at least 24 (three quarters of depth 32), `dma_en` is 1 and `burst_clr` is 0. Otherwise it is 0.
- R3: `dma_req` follows the request chosen by `burst_sel`, both registered at the same edge. With `burst_sel` at 1 it equals `breq`. With `burst_sel` at 0 it equals `sreq`.
- R4: When `single_clr` or `burst_clr` is sampled high, that request is 0 after the edge. It is formed again from `rx_level` at the next edge.
- R5: When `dma_en` is sampled 0, `sreq`, `breq` and `dma_req` are all 0 after that edge.
- R6: The timer advances on `bit_tick` only. `rto_irq` rises one cycle after the 32nd tick that arrives with no restart and a nonzero `rx_level`.
- R7: The timer restarts from zero in any cycle where `rx_char_stb` or `fifo_rd` is high or `rx_level` is 0. Such a cycle's tick is not counted.
- R8: Once set, `rto_irq` stays high until an edge where `tmo_clr` is 1 or `rx_level` is 0. In a cycle where both a clear and a firing tick occur, the clear wins. The interrupt does not fire again until the timer has restarted.
- R9: All outputs are 0 after a synchronous reset on `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 6 | Receive FIFO fill level, 0 to 32 |
| rx_char_stb | input | 1 | One-cycle pulse per character written into the FIFO |
| fifo_rd | input | 1 | One-cycle pulse per FIFO read |
| bit_tick | input | 1 | One pulse per serial bit period |
| dma_en | input | 1 | Global DMA request enable |
| burst_sel | input | 1 | 1 routes the burst request to `dma_req`, 0 routes the single request |
| single_clr | input | 1 | DMA clear handshake for the single request |
| burst_clr | input | 1 | DMA clear handshake for the burst request |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the timeout interrupt |
| sreq | output | 1 | Single-transfer request |
| breq | output | 1 | Burst request |
| dma_req | output | 1 | Selected request to the DMA controller |
| rto_irq | output | 1 | Receive-timeout interrupt |

## Verification
The bound checker checks the following on every cycle:
- both requests, the enable gating and each clear handshake drop the right request one edge later;
- the selected line always equals the request that `burst_sel` named;
- an empty FIFO or a clear strobe removes the interrupt, and the interrupt otherwise holds.

Exact tick counting shows only in the bench's scenarios. These cover the 31st and 32nd ticks, a restart midway through a count, and the interrupt staying silent after a clear until the timer restarts. The bench runs a model of these rules against long random walks of the fill level.

// File: rtl/uart_rx_dma_pkg.sv
package uart_rx_dma_pkg;
  typedef enum logic [0:0] {
    REQ_SINGLE = 1'b0,
    REQ_BURST  = 1'b1
  } req_kind_e;

  localparam int REQ_KINDS = 2;

  function automatic int req_threshold(input int kind, input int depth);
    return (kind == int'(REQ_BURST)) ? (depth * 3) / 4 : 1;
  endfunction
endpackage

// File: rtl/uart_rx_req_unit.sv
module uart_rx_req_unit #(
  parameter int LVL_W  = 6,
  parameter int THRESH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic             en,
  input  logic             clr,
  output logic             req_nxt,
  output logic             req
);
  assign req_nxt = en && !clr && (int'(level) >= THRESH);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= req_nxt;
  end
endmodule

// File: rtl/uart_rx_tmo_timer.sv
module uart_rx_tmo_timer #(
  parameter int LVL_W = 6,
  parameter int TICKS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic             char_stb,
  input  logic             fifo_rd,
  input  logic             bit_tick,
  input  logic             tmo_clr,
  output logic             irq
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);

  logic [CNT_W-1:0] cnt;
  logic             empty;
  logic             restart;
  logic             fire;

  assign empty   = (level == '0);
  assign restart = char_stb || fifo_rd || empty;
  assign fire    = bit_tick && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (bit_tick && cnt != FULL)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || tmo_clr || empty) irq <= 1'b0;
    else if (fire)               irq <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_dma_req.sv
module uart_rx_dma_req #(
  parameter int DEPTH     = 32,
  parameter int TMO_TICKS = 32,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_char_stb,
  input  logic             fifo_rd,
  input  logic             bit_tick,
  input  logic             dma_en,
  input  logic             burst_sel,
  input  logic             single_clr,
  input  logic             burst_clr,
  input  logic             tmo_clr,
  output logic             sreq,
  output logic             breq,
  output logic             dma_req,
  output logic             rto_irq
);
  import uart_rx_dma_pkg::*;

  localparam int BURST_MARK = req_threshold(int'(REQ_BURST), DEPTH);
  localparam int BURST_LEN  = DEPTH / 2;

  logic [REQ_KINDS-1:0] clr_vec;
  logic [REQ_KINDS-1:0] nxt_vec;
  logic [REQ_KINDS-1:0] req_vec;

  assign clr_vec[REQ_SINGLE] = single_clr;
  assign clr_vec[REQ_BURST]  = burst_clr;

  for (genvar k = 0; k < REQ_KINDS; k++) begin : g_req
    uart_rx_req_unit #(
      .LVL_W (LVL_W),
      .THRESH(req_threshold(k, DEPTH))
    ) u_unit (
      .clk    (clk),
      .rst    (rst),
      .level  (rx_level),
      .en     (dma_en),
      .clr    (clr_vec[k]),
      .req_nxt(nxt_vec[k]),
      .req    (req_vec[k])
    );
  end

  assign sreq = req_vec[REQ_SINGLE];
  assign breq = req_vec[REQ_BURST];

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= burst_sel ? nxt_vec[REQ_BURST] : nxt_vec[REQ_SINGLE];
  end

  uart_rx_tmo_timer #(
    .LVL_W(LVL_W),
    .TICKS(TMO_TICKS)
  ) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .level   (rx_level),
    .char_stb(rx_char_stb),
    .fifo_rd (fifo_rd),
    .bit_tick(bit_tick),
    .tmo_clr (tmo_clr),
    .irq     (rto_irq)
  );

  initial begin
    if (BURST_MARK <= BURST_LEN)
      $error("burst watermark must exceed burst length");
  end
endmodule

// File: rtl/uart_rx_dma_req_chk.sv
module uart_rx_dma_req_chk #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] rx_level,
  input logic             dma_en,
  input logic             burst_sel,
  input logic             single_clr,
  input logic             burst_clr,
  input logic             tmo_clr,
  input logic             sreq,
  input logic             breq,
  input logic             dma_req,
  input logic             rto_irq
);
  localparam int MARK = (DEPTH * 3) / 4;

  AST_SREQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !sreq); // R1
  AST_SREQ_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_level != '0 && dma_en && !single_clr) |=> sreq); // R1
  AST_BREQ_MARK: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_level) >= MARK && dma_en && !burst_clr) |=> breq); // R2
  AST_BREQ_LOW: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_level) < MARK) |=> !breq); // R2
  AST_MUX_ROUTE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dma_req == ($past(burst_sel) ? breq : sreq))); // R3
  AST_SCLR_DROP: assert property (@(posedge clk) disable iff (rst)
    single_clr |=> !sreq); // R4
  AST_BCLR_DROP: assert property (@(posedge clk) disable iff (rst)
    burst_clr |=> !breq); // R4
  AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> (!sreq && !breq && !dma_req)); // R5
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0 || tmo_clr) |=> !rto_irq); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rto_irq && !tmo_clr && rx_level != '0) |=> rto_irq); // R8
endmodule

bind uart_rx_dma_req uart_rx_dma_req_chk #(
  .DEPTH(DEPTH),
  .LVL_W(LVL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_level  (rx_level),
  .dma_en    (dma_en),
  .burst_sel (burst_sel),
  .single_clr(single_clr),
  .burst_clr (burst_clr),
  .tmo_clr   (tmo_clr),
  .sreq      (sreq),
  .breq      (breq),
  .dma_req   (dma_req),
  .rto_irq   (rto_irq)
);

// File: tb/uart_rx_dma_req_bench.sv
module uart_rx_dma_req_bench;
  localparam int DEPTH = 32;
  localparam int TICKS = 32;
  localparam int LVL_W = 6;
  localparam int MARK  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LVL_W-1:0] rx_level = '0;
  logic rx_char_stb = 0, fifo_rd = 0, bit_tick = 0, dma_en = 0, burst_sel = 0;
  logic single_clr = 0, burst_clr = 0, tmo_clr = 0;
  logic sreq, breq, dma_req, rto_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit m_s, m_b, m_d, m_irq;
  int m_cnt;

  always #10 clk = ~clk;

  uart_rx_dma_req #(.DEPTH(DEPTH), .TMO_TICKS(TICKS)) u_uart_rx_dma_req (
    .clk(clk), .rst(rst), .rx_level(rx_level), .rx_char_stb(rx_char_stb),
    .fifo_rd(fifo_rd), .bit_tick(bit_tick), .dma_en(dma_en),
    .burst_sel(burst_sel), .single_clr(single_clr), .burst_clr(burst_clr),
    .tmo_clr(tmo_clr), .sreq(sreq), .breq(breq), .dma_req(dma_req),
    .rto_irq(rto_irq)
  );

  function automatic bit f_single(input int lvl, input bit en, input bit clr);
    return en && !clr && lvl >= 1;
  endfunction

  function automatic bit f_burst(input int lvl, input bit en, input bit clr);
    return en && !clr && lvl >= MARK;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic model_update();
    bit restart, fire, ns;
    int lvl;
    lvl = int'(rx_level);
    if (rst) begin
      m_s = 0; m_b = 0; m_d = 0; m_irq = 0; m_cnt = 0;
    end else begin
      ns  = f_single(lvl, dma_en, single_clr);
      m_b = f_burst(lvl, dma_en, burst_clr);
      m_s = ns;
      m_d = burst_sel ? m_b : m_s;
      restart = rx_char_stb || fifo_rd || lvl == 0;
      fire    = bit_tick && !restart && m_cnt == TICKS - 1;
      if (tmo_clr || lvl == 0) m_irq = 0;
      else if (fire)           m_irq = 1;
      if (restart)                          m_cnt = 0;
      else if (bit_tick && m_cnt < TICKS)   m_cnt = m_cnt + 1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_update();
    check("R1/R4/R5 sreq", sreq, m_s);
    check("R2/R4/R5 breq", breq, m_b);
    check("R3/R5 dma_req", dma_req, m_d);
    check("R6/R7/R8 rto_irq", rto_irq, m_irq);
  endtask

  task automatic quiet();
    rx_char_stb = 0; fifo_rd = 0; bit_tick = 0;
    single_clr = 0; burst_clr = 0; tmo_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lvl;
    void'($urandom(42));
    rst = 1; rx_level = 6'd30; dma_en = 1; bit_tick = 1;
    step(); step();
    check("R9 reset sreq", sreq, 0);
    check("R9 reset irq", rto_irq, 0);
    rst = 0; quiet();

    // R2 boundary: 23 vs 24
    rx_level = 6'd23; step();
    check("R2 below mark", breq, 0);
    check("R1 nonempty", sreq, 1);
    rx_level = 6'd24; step();
    check("R2 at mark", breq, 1);
    // R3 routing
    burst_sel = 1; rx_level = 6'd5; step();
    check("R3 burst routed low", dma_req, 0);
    burst_sel = 0; step();
    check("R3 single routed", dma_req, 1);
    // R4 clear then re-evaluate
    single_clr = 1; step();
    check("R4 clear drops", sreq, 0);
    single_clr = 0; step();
    check("R4 re-evaluated", sreq, 1);
    // R5 gate
    dma_en = 0; rx_level = 6'd30; step();
    check("R5 gated sreq", sreq, 0);
    check("R5 gated breq", breq, 0);
    dma_en = 1;

    // R6 exact count, R7 restart midway
    rx_level = 6'd5; rx_char_stb = 1; step(); rx_char_stb = 0;
    bit_tick = 1;
    for (int i = 0; i < 20; i++) step();
    fifo_rd = 1; step(); fifo_rd = 0;
    check("R7 read restarts", rto_irq, 0);
    for (int i = 0; i < 31; i++) step();
    check("R6 31 ticks no irq", rto_irq, 0);
    step();
    check("R6 32nd tick irq", rto_irq, 1);
    bit_tick = 0;
    for (int i = 0; i < 5; i++) step();
    check("R8 irq holds", rto_irq, 1);
    tmo_clr = 1; step(); tmo_clr = 0;
    check("R8 w1c clears", rto_irq, 0);
    bit_tick = 1;
    for (int i = 0; i < 40; i++) step();
    check("R8 no refire", rto_irq, 0);
    rx_char_stb = 1; step(); rx_char_stb = 0;
    for (int i = 0; i < 32; i++) step();
    check("R6 refire after restart", rto_irq, 1);
    rx_level = '0; step();
    check("R8 empty clears", rto_irq, 0);

    // random
    lvl = 10;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 40 == 0) lvl = $urandom % (DEPTH + 1);
      else lvl = lvl + int'($urandom % 3) - 1;
      if (lvl < 0) lvl = 0;
      if (lvl > DEPTH) lvl = DEPTH;
      rx_level    = LVL_W'(lvl);
      bit_tick    = ($urandom % 2) == 0;
      rx_char_stb = ($urandom % 70) == 0;
      fifo_rd     = ($urandom % 90) == 0;
      single_clr  = ($urandom % 12) == 0;
      burst_clr   = ($urandom % 12) == 0;
      tmo_clr     = ($urandom % 150) == 0;
      if ($urandom % 60 == 0) burst_sel = ~burst_sel;
      if ($urandom % 200 == 0) dma_en = ~dma_en;
      step();
    end
    finish_run();
  end
endmodule